// File: doc/BRIEF.md
# Tightly Coupled Memory Window Decoder

This block keeps two address windows for fast local memory next to a processor core: one window for data and one for instructions. Each window is described by a settings word loaded through a small register-write port, and is switched on by its own bit of a control word supplied by the core's control register. From each settings word the block works out the window size, the compare mask and the window base. It then flags, for the address presented on the lookup port, whether that address falls inside each window.

The size comes from a five-bit exponent field that scales a 512-byte unit. The data window is held to a 4 KB floor and may sit on any 4 KB-aligned base. The instruction window always starts at address zero. A disabled window takes a base and mask that no address can match. A fixed size-report word tells software how large the physical memories behind the two windows are.

Top module: `tcm_window_decoder`

## Requirements
- R1: On reset, both settings words read 0 and both windows are disabled: sizes 0, masks 0, bases 0xFFFFFFFF, no hits.
- R2: A write with `cfg_sel`=0 stores `cfg_wdata & 0xFFFFF03E` as the data settings. A write with `cfg_sel`=1 stores `cfg_wdata & 0x0000003E` as the instruction settings. Each is visible the cycle after the write edge.
- R3: Control bit 16 enables the data window and control bit 18 enables the instruction window. A change on `ctrl_word` shows on the outputs only after the next clock edge.
- R4: An enabled window's raw size is 0x200 shifted left by settings bits [5:1], truncated to 32 bits. An exponent of 23 or more wraps the raw size to 0.
- R5: The enabled data window size is never below 0x1000. A raw size under 0x1000, including a wrapped 0, becomes 0x1000.
- R6: The enabled data window mask is 0xFFFFF000 & ~(size-1), and its base is the settings word ANDed with that mask.
- R7: The enabled instruction window has base 0 and mask ~(size-1), so addresses below the size hit. A wrapped size of 0 gives mask 0, and every address then hits.
- R8: A disabled window reports size 0, mask 0 and base 0xFFFFFFFF, and never hits.
- R9: Each hit output equals ((lookup_addr & mask) == base). It follows `lookup_addr` in the same cycle, without a clock edge.
- R10: `size_report_o` always reads 0x00140180. Bits [8:6] hold 6, which means a 32 KB instruction memory, and bits [20:18] hold 5, which means a 16 KB data memory.
- R11: A settings word changes only on a write to its own window. Clearing and then setting an enable bit restores the same window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_sel | input | 1 | Window to write: 0 data, 1 instruction |
| cfg_wdata | input | 32 | Settings write data |
| ctrl_word | input | 32 | Control register value; bits 16 and 18 are used |
| lookup_addr | input | 32 | Address to classify |
| d_setting_o | output | 32 | Stored data settings |
| i_setting_o | output | 32 | Stored instruction settings |
| d_size_o | output | 32 | Data window size in bytes |
| d_mask_o | output | 32 | Data window compare mask |
| d_base_o | output | 32 | Data window base |
| i_size_o | output | 32 | Instruction window size in bytes |
| i_mask_o | output | 32 | Instruction window compare mask |
| i_base_o | output | 32 | Instruction window base |
| d_hit_o | output | 1 | Lookup address is inside the data window |
| i_hit_o | output | 1 | Lookup address is inside the instruction window |
| size_report_o | output | 32 | Fixed memory size report |

## Verification
The assertions assume that `cfg_we`, `cfg_sel` and `ctrl_word` are driven to known values in every cycle after reset. They also assume that a settings write and a control change may land in the same cycle without any ordering between them. The stimulus changes every input only at the falling clock edge. It holds `cfg_we` high for exactly one rising edge per write, and it leaves `lookup_addr` free to move between edges, because hits are purely combinational. The exponent values are picked to cover the data floor, the 32-bit wrap and the largest size that still fits, without ever leaving a control or settings input undriven.

// File: rtl/tcm_pkg.sv
// Shared constants and types for the local-memory window decoder.
// Assumes a 32-bit address space and a 512-byte size unit.
package tcm_pkg;
    localparam int unsigned AW        = 32;
    typedef logic [AW-1:0] word_t;

    // Derived description of one window
    typedef struct packed {
        word_t size;
        word_t mask;
        word_t base;
    } win_t;

    localparam int unsigned NWIN      = 2;   // index 0 data, 1 instruction
    localparam int unsigned EXP_LSB   = 1;
    localparam int unsigned EXP_W     = 5;
    localparam int unsigned MIN_EXP   = 3;
    localparam word_t SIZE_UNIT       = 32'h0000_0200;
    localparam word_t D_KEEP          = 32'hFFFF_F03E;
    localparam word_t I_KEEP          = 32'h0000_003E;
    localparam word_t D_LIMIT         = 32'hFFFF_F000;
    localparam word_t I_LIMIT         = 32'hFFFF_FFFF;
    localparam int unsigned D_EN_BIT  = 16;
    localparam int unsigned I_EN_BIT  = 18;
    localparam int unsigned RPT_I_CODE = 6;
    localparam int unsigned RPT_I_POS  = 6;
    localparam int unsigned RPT_D_CODE = 5;
    localparam int unsigned RPT_D_POS  = 18;
endpackage

// File: rtl/tcm_setting_reg.sv
// Holds one window's settings word, keeping only the bits named by KEEP.
// Assumes a synchronous active-low reset; a write lands on the next edge.
module tcm_setting_reg
    import tcm_pkg::*;
#(
    parameter word_t KEEP = 32'hFFFF_FFFF
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  word_t wdata,
    output word_t q
);
    // Settings storage: clear on reset, masked load on write
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata & KEEP;
    end

    a_r2_kept_bits: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == ($past(wdata) & KEEP)));
    a_r11_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/tcm_window_calc.sv
// Turns a settings word and an enable into size, mask and base.
// CLAMP selects the minimum-size floor; LIMIT bounds which mask bits may be set.
module tcm_window_calc
    import tcm_pkg::*;
#(
    parameter word_t LIMIT = 32'hFFFF_FFFF,
    parameter bit    CLAMP = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  word_t setting,
    output win_t  win_o
);
    localparam word_t MIN_SIZE = SIZE_UNIT << MIN_EXP;

    logic [EXP_W-1:0] expo;
    word_t            raw;
    word_t            sz;

    // Size from the exponent field, optionally held at the floor
    always_comb begin
        expo = setting[EXP_LSB +: EXP_W];
        raw  = SIZE_UNIT << expo;
        sz   = (CLAMP && (raw < MIN_SIZE)) ? MIN_SIZE : raw;
    end

    // Window description, or an unmatched one when disabled
    always_comb begin
        if (en) begin
            win_o.size = sz;
            win_o.mask = LIMIT & ~(sz - 32'd1);
            win_o.base = setting & win_o.mask;
        end else begin
            win_o.size = '0;
            win_o.mask = '0;
            win_o.base = '1;
        end
    end

    a_r4_size_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> $onehot0(win_o.size));

    if (CLAMP) begin : g_floor
        a_r5_size_floor: assert property (@(posedge clk) disable iff (!rst_n)
            en |-> (win_o.size >= MIN_SIZE));
    end
endmodule

// File: rtl/tcm_window_match.sv
// Compares one address against one window's mask and base.
// Assumes a disabled window carries a base that no masked address can equal.
module tcm_window_match
    import tcm_pkg::*;
(
    input  word_t addr,
    input  win_t  win,
    output logic  hit
);
    // Masked compare
    assign hit = ((addr & win.mask) == win.base);
endmodule

// File: rtl/tcm_window_decoder.sv
// Two local-memory windows (data, instruction) with settings, enables and hits.
// Assumes ctrl_word mirrors the core's control register; only bits 16 and 18 matter.
module tcm_window_decoder
    import tcm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic [31:0] ctrl_word,
    input  logic [31:0] lookup_addr,
    output logic [31:0] d_setting_o,
    output logic [31:0] i_setting_o,
    output logic [31:0] d_size_o,
    output logic [31:0] d_mask_o,
    output logic [31:0] d_base_o,
    output logic [31:0] i_size_o,
    output logic [31:0] i_mask_o,
    output logic [31:0] i_base_o,
    output logic        d_hit_o,
    output logic        i_hit_o,
    output logic [31:0] size_report_o
);
    logic [NWIN-1:0] en_q;
    logic [NWIN-1:0] hit;
    word_t           setting_q [NWIN];
    win_t            win       [NWIN];

    logic unused_ctrl;
    assign unused_ctrl = ^{ctrl_word[31:19], ctrl_word[17], ctrl_word[15:0]};

    // Capture the window enables from the control word
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= {ctrl_word[I_EN_BIT], ctrl_word[D_EN_BIT]};
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        localparam word_t       KEEP   = (w == 0) ? D_KEEP  : I_KEEP;
        localparam word_t       LIMIT  = (w == 0) ? D_LIMIT : I_LIMIT;
        localparam bit          CLAMP  = (w == 0);
        localparam logic        SEL    = (w == 0) ? 1'b0 : 1'b1;
        localparam int unsigned EN_BIT = (w == 0) ? D_EN_BIT : I_EN_BIT;

        logic we_w;
        assign we_w = cfg_we && (cfg_sel == SEL);

        tcm_setting_reg #(.KEEP(KEEP)) i_setting (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we_w),
            .wdata (cfg_wdata),
            .q     (setting_q[w])
        );

        tcm_window_calc #(.LIMIT(LIMIT), .CLAMP(CLAMP)) i_calc (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en_q[w]),
            .setting (setting_q[w]),
            .win_o   (win[w])
        );

        tcm_window_match i_match (
            .addr (lookup_addr),
            .win  (win[w]),
            .hit  (hit[w])
        );

        a_r8_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_word[EN_BIT] |=> !hit[w]);
        a_r3_enable_follows: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_word[EN_BIT] |=> (win[w].base != 32'hFFFF_FFFF));
    end

    // Output mapping
    assign d_setting_o = setting_q[0];
    assign i_setting_o = setting_q[1];
    assign d_size_o    = win[0].size;
    assign d_mask_o    = win[0].mask;
    assign d_base_o    = win[0].base;
    assign i_size_o    = win[1].size;
    assign i_mask_o    = win[1].mask;
    assign i_base_o    = win[1].base;
    assign d_hit_o     = hit[0];
    assign i_hit_o     = hit[1];
    assign size_report_o = (word_t'(RPT_I_CODE) << RPT_I_POS)
                         | (word_t'(RPT_D_CODE) << RPT_D_POS);
endmodule

// File: tb/test_tcm_window_decoder.sv
`timescale 1ns/1ps
module test_tcm_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] ctrl_word = '0;
    logic [31:0] lookup_addr = '0;
    logic [31:0] d_setting_o, i_setting_o, d_size_o, d_mask_o, d_base_o;
    logic [31:0] i_size_o, i_mask_o, i_base_o, size_report_o;
    logic        d_hit_o, i_hit_o;

    int checks = 0;
    int errors = 0;

    // Bench-side model state
    logic [31:0] m_ds = '0, m_is = '0;
    bit          m_den = 0, m_ien = 0;

    always #2 clk = ~clk;

    tcm_window_decoder i_tcm_window_decoder (
        .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .ctrl_word, .lookup_addr,
        .d_setting_o, .i_setting_o, .d_size_o, .d_mask_o, .d_base_o,
        .i_size_o, .i_mask_o, .i_base_o, .d_hit_o, .i_hit_o, .size_report_o
    );

    function automatic logic [31:0] m_size(input logic [31:0] s, input bit data, input bit en);
        logic [31:0] r;
        if (!en) return 32'h0;
        r = 32'h200 << s[5:1];
        if (data && r < 32'h1000) r = 32'h1000;
        return r;
    endfunction

    function automatic logic [31:0] m_mask(input logic [31:0] sz, input bit data, input bit en);
        if (!en) return 32'h0;
        return data ? (32'hFFFF_F000 & ~(sz - 1)) : ~(sz - 1);
    endfunction

    function automatic logic [31:0] m_base(input logic [31:0] s, input logic [31:0] mk, input bit en);
        if (!en) return 32'hFFFF_FFFF;
        return s & mk;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic chk_windows(input string req);
        logic [31:0] dsz, dmk, isz, imk;
        dsz = m_size(m_ds, 1, m_den);
        dmk = m_mask(dsz, 1, m_den);
        isz = m_size(m_is, 0, m_ien);
        imk = m_mask(isz, 0, m_ien);
        chk({req, " d_size"}, d_size_o, dsz);
        chk({req, " d_mask"}, d_mask_o, dmk);
        chk({req, " d_base"}, d_base_o, m_base(m_ds, dmk, m_den));
        chk({req, " i_size"}, i_size_o, isz);
        chk({req, " i_mask"}, i_mask_o, imk);
        chk({req, " i_base"}, i_base_o, m_base(m_is, imk, m_ien));
    endtask

    // Present an address and compare both hits with the model (R9)
    task automatic probe(input string req, input logic [31:0] a);
        logic [31:0] dmk, imk;
        dmk = m_mask(m_size(m_ds, 1, m_den), 1, m_den);
        imk = m_mask(m_size(m_is, 0, m_ien), 0, m_ien);
        lookup_addr = a;
        #0.5;
        chk({req, " d_hit"}, {31'b0, d_hit_o}, {31'b0, ((a & dmk) == m_base(m_ds, dmk, m_den))});
        chk({req, " i_hit"}, {31'b0, i_hit_o}, {31'b0, ((a & imk) == m_base(m_is, imk, m_ien))});
    endtask

    task automatic wr(input logic sel, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) m_is = v & 32'h0000_003E;
        else     m_ds = v & 32'hFFFF_F03E;
    endtask

    task automatic set_ctrl(input logic [31:0] v);
        @(negedge clk);
        ctrl_word = v;
        #0.5;
        chk_windows("R3 before edge");
        @(negedge clk);
        m_den = v[16];
        m_ien = v[18];
    endtask

    task automatic t_reset_state;
        chk("R1 d_setting", d_setting_o, 32'h0);
        chk("R1 i_setting", i_setting_o, 32'h0);
        chk_windows("R1");
        chk("R1 d_base", d_base_o, 32'hFFFF_FFFF);
        probe("R1", 32'h0);
        probe("R1", 32'hFFFF_FFFF);
        chk("R10 report", size_report_o, 32'h0014_0180);
    endtask

    task automatic t_write_masks;
        wr(1'b0, 32'hFFFF_FFFF);
        chk("R2 data keep", d_setting_o, 32'hFFFF_F03E);
        chk("R11 instr untouched", i_setting_o, 32'h0);
        wr(1'b1, 32'hFFFF_FFFF);
        chk("R2 instr keep", i_setting_o, 32'h0000_003E);
        chk("R11 data untouched", d_setting_o, 32'hFFFF_F03E);
        chk_windows("R8 writes while off");
        probe("R8", 32'hFFFF_F000);
    endtask

    task automatic t_data_window;
        int fields [7] = '{0, 3, 4, 7, 22, 23, 31};
        set_ctrl(32'h0001_0000);
        foreach (fields[k]) begin
            logic [31:0] sz, bs;
            wr(1'b0, 32'h0270_0000 | (32'(fields[k]) << 1) | 32'h1);
            chk_windows("R4 R5 R6 data");
            sz = m_size(m_ds, 1, 1);
            bs = m_base(m_ds, m_mask(sz, 1, 1), 1);
            if (fields[k] == 0 || fields[k] >= 23)
                chk("R5 floor", d_size_o, 32'h1000);
            probe("R6 base", bs);
            probe("R6 last", bs + sz - 1);
            probe("R6 above", bs + sz);
            probe("R6 below", bs - 1);
        end
    endtask

    task automatic t_instr_window;
        int fields [4] = '{0, 6, 22, 23};
        set_ctrl(32'h0005_0000);
        foreach (fields[k]) begin
            logic [31:0] sz;
            wr(1'b1, 32'hABCD_E000 | (32'(fields[k]) << 1));
            chk_windows("R4 R7 instr");
            chk("R7 base zero", i_base_o, 32'h0);
            sz = m_size(m_is, 0, 1);
            probe("R7 zero", 32'h0);
            probe("R7 last", sz - 1);
            probe("R7 size", sz);
            probe("R7 top", 32'hFFFF_FFFF);
        end
        chk("R7 wrap all hit", {31'b0, i_hit_o}, 32'h1);
    endtask

    task automatic t_disable_restore;
        logic [31:0] dsave, isave;
        wr(1'b0, 32'h0080_0000 | (32'd5 << 1));
        wr(1'b1, 32'd4 << 1);
        dsave = d_base_o;
        isave = i_size_o;
        set_ctrl(32'h0000_0000);
        chk_windows("R8 off");
        probe("R8 off", dsave);
        probe("R8 off", 32'h0);
        set_ctrl(32'h0004_0000);
        chk_windows("R3 instr only");
        set_ctrl(32'h0005_0000);
        chk("R11 d_base restored", d_base_o, dsave);
        chk("R11 i_size restored", i_size_o, isave);
        probe("R9 moving addr", 32'h0080_0010);
        probe("R9 moving addr", 32'h0000_1FFF);
    endtask

    task automatic t_reset_again;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        ctrl_word = '0;
        m_ds = '0; m_is = '0; m_den = 0; m_ien = 0;
        chk("R1 d_setting after reset", d_setting_o, 32'h0);
        chk("R1 i_setting after reset", i_setting_o, 32'h0);
        chk_windows("R1 after reset");
        @(negedge clk);
        chk_windows("R1 steady");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_write_masks();
        t_data_window();
        t_instr_window();
        t_disable_restore();
        t_reset_again();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule